// File: doc/BRIEF.md
# Protected Register Unlock Guard

This block stands on a small I/O write bus and decides, each cycle, whether a write to one of three guarded control registers may go through. The guarded registers are the clock-source select, the clock prescaler and the watchdog control. Software must first store the unlock key into a dedicated key register. That opens a short window, measured in retired instructions rather than clock cycles. A write to a guarded register lands only while that window is open.

While the window is open, the block asks the CPU to hold off all interrupts. When the window closes, interrupt handling resumes without further action. Reading the key register never returns the stored key. Instead it shows one live status bit that reports whether the window is open.

The window lets exactly one guarded write through and then shuts. Writing a wrong key cancels an open window. Writing the right key again starts the count over.

Top module: `cfg_guard`

## Requirements
- R1: After an asynchronous reset the window is closed, `irq_block` is 0 and the key register reads 0x00. Asserting reset closes the window and drops `irq_block` without waiting for a clock edge.
- R2: A write of 0xD8 to I/O address 0x3C opens the window from the next clock edge. The cycle in which the key is written does not count as one of the window's instruction cycles, even if `insn_retire` is high in that cycle.
- R3: The window closes once four `insn_retire` pulses have been seen after the key write. Clock cycles without a retire pulse do not shorten the window.
- R4: While the window is open, a write to a guarded address raises the matching bit of `prot_we` in the same cycle. Bit 0 belongs to address 0x35 (clock select), bit 1 to 0x36 (prescaler) and bit 2 to 0x31 (watchdog).
- R5: A write to a guarded address while the window is closed leaves `prot_we` at zero.
- R6: An accepted guarded write closes the window at the next edge, so one key permits one guarded write.
- R7: Any value other than 0xD8 written to 0x3C closes an open window and does not open a closed one.
- R8: Writing 0xD8 to 0x3C while the window is open restarts the count at four instruction cycles.
- R9: Reading address 0x3C returns bit 0 equal to the window state and bits 7:1 as zero. Reading any other address returns 0x00.
- R10: `irq_block` is 1 exactly while the window is open.
- R11: Writes to addresses that are neither the key nor a guarded register neither close nor extend the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | Write address |
| io_wdata | input | 8 | Write data |
| io_we | input | 1 | Write strobe |
| insn_retire | input | 1 | One pulse per retired instruction |
| io_raddr | input | 6 | Read address |
| key_rdata | output | 8 | Key register read data (0 for other addresses) |
| prot_we | output | 3 | Per-register write qualifiers for the guarded registers |
| irq_block | output | 1 | Interrupt suppress request to the CPU |

## Verification
The hardest case to reach is a guarded write that lands on the last instruction cycle of the window, or just after it. That edge depends on how many retire pulses, not clock cycles, have passed since the key write. To reach it, the stimulus writes the key and then sends between zero and six retire pulses, each followed by an idle clock with no retire. It then attempts a write to each guarded register in turn, so every position just inside and just outside the window is visited for all three targets. Re-keying, wrong keys and a reset in the middle of a window are driven as separate sequences.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  // Result of decoding one bus write against the key register
  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_GOOD = 2'd1,
    KEY_BAD  = 2'd2
  } key_cmd_e;
endpackage

// File: rtl/cfg_key_decode.sv
module cfg_key_decode
  import cfg_guard_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR = 6'h3C,
  parameter logic [DW-1:0] KEY_VAL = 8'hD8,
  parameter int NPROT = 3,
  parameter logic [NPROT*AW-1:0] PROT_ADDRS = {6'h31, 6'h36, 6'h35}
) (
  input  logic [AW-1:0]    io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_we,
  output key_cmd_e         key_cmd,
  output logic [NPROT-1:0] prot_sel
);
  logic key_wr;

  assign key_wr = io_we && (io_addr == KEY_ADDR);

  always_comb begin
    if (!key_wr)                key_cmd = KEY_NONE;
    else if (io_wdata == KEY_VAL) key_cmd = KEY_GOOD;
    else                        key_cmd = KEY_BAD;
  end

  for (genvar g = 0; g < NPROT; g++) begin : g_sel
    assign prot_sel[g] = io_we && (io_addr == PROT_ADDRS[g*AW +: AW]);
  end
endmodule

// File: rtl/cfg_unlock_window.sv
module cfg_unlock_window
  import cfg_guard_pkg::*;
#(
  parameter int WIN_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  key_cmd_e key_cmd,
  input  logic     prot_fire,
  input  logic     insn_retire,
  output logic     win_open
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] WIN_CNT = CW'(WIN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign win_open = (cnt_q != '0);

  // next-state: key write wins, then one-shot close, then retire countdown
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (key_cmd == KEY_GOOD) begin
      cnt_en = 1'b1;
      cnt_d  = WIN_CNT;
    end else if (key_cmd == KEY_BAD || prot_fire) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (win_open && insn_retire) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_CNT);
  a_r2_open_full: assert property (@(posedge clk) disable iff (!rst_n)
    key_cmd == KEY_GOOD |=> cnt_q == WIN_CNT);
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && insn_retire && key_cmd == KEY_NONE && !prot_fire)
      |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_retire && key_cmd == KEY_NONE && !prot_fire) |=> $stable(cnt_q));
endmodule

// File: rtl/cfg_key_readback.sv
module cfg_key_readback #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR = 6'h3C
) (
  input  logic [AW-1:0] io_raddr,
  input  logic          win_open,
  output logic [DW-1:0] key_rdata
);
  always_comb begin
    key_rdata = '0;
    if (io_raddr == KEY_ADDR) key_rdata[0] = win_open;
  end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR = 6'h3C,
  parameter logic [DW-1:0] KEY_VAL = 8'hD8,
  parameter int NPROT = 3,
  parameter logic [NPROT*AW-1:0] PROT_ADDRS = {6'h31, 6'h36, 6'h35},
  parameter int WIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_we,
  input  logic             insn_retire,
  input  logic [AW-1:0]    io_raddr,
  output logic [DW-1:0]    key_rdata,
  output logic [NPROT-1:0] prot_we,
  output logic             irq_block
);
  key_cmd_e         key_cmd;
  logic [NPROT-1:0] prot_sel;
  logic             win_open;

  cfg_key_decode #(
    .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY_VAL(KEY_VAL),
    .NPROT(NPROT), .PROT_ADDRS(PROT_ADDRS)
  ) u_dec (
    .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we),
    .key_cmd(key_cmd), .prot_sel(prot_sel)
  );

  cfg_unlock_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .key_cmd(key_cmd),
    .prot_fire(|prot_we), .insn_retire(insn_retire), .win_open(win_open)
  );

  cfg_key_readback #(.AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR)) u_rb (
    .io_raddr(io_raddr), .win_open(win_open), .key_rdata(key_rdata)
  );

  assign prot_we   = prot_sel & {NPROT{win_open}};
  assign irq_block = win_open;

  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_we));
  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    ((|prot_we) && key_cmd == KEY_NONE) |=> !irq_block);
  a_r7_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    key_cmd == KEY_BAD |=> (!irq_block && key_rdata[DW-1:1] == '0));
  a_r2_opens: assert property (@(posedge clk) disable iff (!rst_n)
    key_cmd == KEY_GOOD |=> irq_block);
endmodule

// File: tb/tb_cfg_guard.sv
module tb_cfg_guard;
  localparam logic [5:0] KA = 6'h3C;
  localparam logic [7:0] KV = 8'hD8;
  localparam logic [17:0] PA = {6'h31, 6'h36, 6'h35};

  logic       clk;
  logic       rst_n;
  logic [5:0] io_addr;
  logic [7:0] io_wdata;
  logic       io_we;
  logic       insn_retire;
  logic [5:0] io_raddr;
  logic [7:0] key_rdata;
  logic [2:0] prot_we;
  logic       irq_block;

  int total = 0;
  int bad = 0;
  bit done = 0;

  cfg_guard dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_we(io_we), .insn_retire(insn_retire), .io_raddr(io_raddr),
    .key_rdata(key_rdata), .prot_we(prot_we), .irq_block(irq_block)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bus cycle at the falling edge; outputs settle 2 ns later
  task automatic step(input logic [5:0] a, input logic [7:0] d,
                      input logic we, input logic ret);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_we = we; insn_retire = ret;
    #2;
  endtask

  task automatic idle(input logic ret);
    step(6'h00, 8'h00, 1'b0, ret);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_we = 1'b0;
    insn_retire = 1'b0; io_raddr = KA;
    #35;
    chk(irq_block, 0, "R1 irq in reset");
    chk(key_rdata, 0, "R1 readback in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(1'b1);
    chk(irq_block, 0, "R1 after reset");
    chk(prot_we, 0, "R1 prot_we after reset");

    // R2/R3/R4/R5/R6/R10 sweep: key, d retires, then write each target
    for (int i = 0; i < 3; i++) begin
      for (int d = 0; d < 7; d++) begin
        step(KA, KV, 1'b1, 1'b1);          // retire in key cycle does not count
        idle(1'b0);
        chk(irq_block, 1, "R2 window open");
        chk(key_rdata, 1, "R9 status bit");
        for (int k = 0; k < d; k++) begin
          idle(1'b1);
          idle(1'b0);                       // plain clocks do not count (R3)
        end
        step(PA[i*6 +: 6], 8'h5A, 1'b1, 1'b0);
        chk(irq_block, (d < 4) ? 1 : 0, "R10/R3 open iff retires<4");
        chk(prot_we, (d < 4) ? (1 << i) : 0, (d < 4) ? "R4 accepted" : "R5 dropped");
        idle(1'b0);
        chk(irq_block, 0, "R6 closed after write");
        chk(key_rdata, 0, "R9 closed readback");
      end
    end

    // R8: rekey restarts the count
    step(KA, KV, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) idle(1'b1);
    step(KA, KV, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) idle(1'b1);
    chk(irq_block, 1, "R8 still open after rekey");
    idle(1'b1);
    idle(1'b0);
    chk(irq_block, 0, "R8 closes after four more");

    // R7: wrong keys close and never open
    for (int v = 0; v < 256; v++) begin
      if (v[7:0] != KV) begin
        step(KA, KV, 1'b1, 1'b0);
        step(KA, v[7:0], 1'b1, 1'b0);
        chk(irq_block, 1, "R7 open before bad key");
        idle(1'b0);
        chk(irq_block, 0, "R7 bad key closes");
        step(PA[0 +: 6], 8'h11, 1'b1, 1'b0);
        chk(prot_we, 0, "R7 no write after bad key");
        idle(1'b0);
      end
    end

    // R11: unrelated writes keep the window as it is
    step(KA, KV, 1'b1, 1'b0);
    for (int a = 0; a < 64; a++) begin
      if (a != KA && a != PA[0 +: 6] && a != PA[6 +: 6] && a != PA[12 +: 6])
        step(a[5:0], 8'hD8, 1'b1, 1'b0);
    end
    idle(1'b0);
    chk(irq_block, 1, "R11 unrelated writes ignored");

    // R9: readback at every address while open, then closed
    for (int a = 0; a < 64; a++) begin
      io_raddr = a[5:0];
      #1;
      chk(key_rdata, (a == KA) ? 1 : 0, "R9 readback open");
    end
    for (int k = 0; k < 4; k++) idle(1'b1);
    for (int a = 0; a < 64; a++) begin
      io_raddr = a[5:0];
      #1;
      chk(key_rdata, 0, "R9 readback closed");
    end
    io_raddr = KA;

    // R1: reset in the middle of a window closes at once
    step(KA, KV, 1'b1, 1'b0);
    idle(1'b0);
    chk(irq_block, 1, "R1 open before reset");
    rst_n = 1'b0;
    #1;
    chk(irq_block, 0, "R1 reset drops irq_block");
    chk(key_rdata, 0, "R1 reset readback");
    step(PA[12 +: 6], 8'h22, 1'b1, 1'b0);
    chk(prot_we, 0, "R1 no write in reset");
    rst_n = 1'b1;
    idle(1'b0);
    chk(irq_block, 0, "R1 stays closed");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule